// File: doc/BRIEF.md
# Virtual Interrupt Injection Controller

This block is the interrupt-controller slice that serves one virtual supervisor context. It merges two kinds of interrupt sources into one guest-facing claim/complete interface. The first kind is a small set of list-style injection entries that the hypervisor fills by software. The second kind is a vector of directly assigned physical sources, each with its own priority and enable. The guest claims and completes interrupts against the hardware directly, so no hypervisor trap is needed. The block drives the guest external-interrupt line whenever an interrupt can be selected.

Each injection entry follows a lifecycle. Software writes an ID and a priority, and the entry becomes pending. A guest claim that selects the entry marks it in flight, and a guest complete with the same ID empties it. A management interrupt tells the hypervisor about two conditions: no entry is left pending, or the guest completed an ID that no entry holds. Each condition has its own enable, and its status is visible in a management register.

All registers are 32 bits wide and byte-addressed on a simple read/write bus. Read data is combinational from the address, and side effects take place at the clock edge. Injection entry k sits at byte offset 4*k. The claim/complete register is at 0x40. The management register is at 0x44.

Top module: `virq_inject_ctrl`

## Requirements
- R1: After reset, every entry reads 0, a claim returns 0, the management register reads 0x00000001 (no-pending status set, both enables clear), and guestIrq and mgmtIrq are low.
- R2: The entry word layout is bit 31 in-flight, bits 16+PRIO_W-1:16 priority, and bits 9:0 ID. Written fields read back unchanged. Entry offsets at or beyond NUM_ENTRIES read 0 and ignore writes.
- R3: An entry is pending when its ID is non-zero and its in-flight bit is clear. Only a pending entry or an enabled pending physical source with non-zero priority can be selected, and guestIrq is high exactly when such a candidate exists.
- R4: A read of 0x40 returns the ID of the candidate with the highest priority. Physical source j carries ID j+1, and a source whose enable is low is never selected.
- R5: Equal priorities resolve to the lowest ID. A virtual entry beats a physical source with the same ID and priority.
- R6: A claim that selects an entry sets that entry's in-flight bit. A claim that selects a physical source changes no entry.
- R7: A claim with no candidate returns 0 and changes no state.
- R8: A write of a non-zero ID to 0x40 clears every entry holding that ID, in all fields.
- R9: A complete whose ID is non-zero, greater than NUM_PHYS and held by no entry latches the unmatched status (management bit 1). Writing 1 to bit 1 clears it. Completes of physical-range IDs never set it.
- R10: Management bit 0 reads 1 exactly when no entry is pending. Bits 8 and 9 enable the no-pending and unmatched events. mgmtIrq is the OR of the enabled statuses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (claim side effect at 0x40) |
| regAddr | input | 8 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| physPending | input | NUM_PHYS | Physical source pending bits |
| physEnable | input | NUM_PHYS | Physical source enables |
| physPrio | input | NUM_PHYS*PRIO_W | Per-source priority, source j at bits j*PRIO_W |
| guestIrq | output | 1 | Guest external-interrupt line |
| mgmtIrq | output | 1 | Block management interrupt to the hypervisor |

## Verification
The hardest case to reach is a single claim that must choose between a virtual entry and a physical source holding the same ID and priority. Right after that, the physical source must win the following claims while the entry sits in flight. The stimulus builds this case by programming an entry with the same ID as an enabled physical source. A higher-priority physical source is held pending but disabled. The stimulus then claims repeatedly and reads the entry back between claims. Finally it enables the high-priority source to show the selection move.

// File: rtl/virq_inject_pkg.sv
package virq_inject_pkg;
  localparam int ID_W  = 10;
  localparam int IDX_W = 4;
  localparam int WORD_CLAIM = 16;
  localparam int WORD_MGMT  = 17;

  typedef struct packed {
    logic             entryWr;
    logic [IDX_W-1:0] entryIdx;
    logic             claim;
    logic             complete;
    logic [31:0]      wdata;
  } virq_strobe_t;
endpackage

// File: rtl/virq_inject_dp.sv
module virq_inject_dp
  import virq_inject_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_PHYS    = 8,
  parameter int PRIO_W      = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  virq_strobe_t               strb,
  input  logic [NUM_PHYS-1:0]        physPending,
  input  logic [NUM_PHYS-1:0]        physEnable,
  input  logic [NUM_PHYS*PRIO_W-1:0] physPrio,
  output logic [NUM_ENTRIES*32-1:0]  entryWords,
  output logic                       bestValid,
  output logic [ID_W-1:0]            bestId,
  output logic                       anyPending,
  output logic                       completeHit
);
  logic [NUM_ENTRIES-1:0]             entInFl;
  logic [NUM_ENTRIES-1:0][PRIO_W-1:0] entPrio;
  logic [NUM_ENTRIES-1:0][ID_W-1:0]   entId;
  logic [NUM_ENTRIES-1:0]             entPend;
  logic [NUM_ENTRIES-1:0]             entHit;
  logic [PRIO_W-1:0]                  bestPrio;
  logic                               bestVirt;
  logic [IDX_W-1:0]                   bestIdx;
  logic [ID_W-1:0]                    cmpId;

  assign cmpId = strb.wdata[ID_W-1:0];

  always_comb begin
    bestValid = 1'b0;
    bestPrio  = '0;
    bestId    = '0;
    bestVirt  = 1'b0;
    bestIdx   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entPend[i] && entPrio[i] != '0 &&
          (!bestValid || entPrio[i] > bestPrio ||
           (entPrio[i] == bestPrio && entId[i] < bestId))) begin
        bestValid = 1'b1;
        bestPrio  = entPrio[i];
        bestId    = entId[i];
        bestVirt  = 1'b1;
        bestIdx   = IDX_W'(i);
      end
    end
    for (int j = 0; j < NUM_PHYS; j++) begin
      if (physPending[j] && physEnable[j] && physPrio[j*PRIO_W +: PRIO_W] != '0 &&
          (!bestValid || physPrio[j*PRIO_W +: PRIO_W] > bestPrio ||
           (physPrio[j*PRIO_W +: PRIO_W] == bestPrio && ID_W'(j + 1) < bestId))) begin
        bestValid = 1'b1;
        bestPrio  = physPrio[j*PRIO_W +: PRIO_W];
        bestId    = ID_W'(j + 1);
        bestVirt  = 1'b0;
        bestIdx   = '0;
      end
    end
  end

  assign anyPending  = |entPend;
  assign completeHit = |entHit;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    assign entPend[i] = (entId[i] != '0) && !entInFl[i];
    assign entHit[i]  = (cmpId != '0) && (entId[i] == cmpId);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entInFl[i] <= 1'b0;
        entPrio[i] <= '0;
        entId[i]   <= '0;
      end else if (strb.entryWr && strb.entryIdx == IDX_W'(i)) begin
        entInFl[i] <= strb.wdata[31];
        entPrio[i] <= strb.wdata[16 +: PRIO_W];
        entId[i]   <= strb.wdata[ID_W-1:0];
      end else if (strb.complete && entHit[i]) begin
        entInFl[i] <= 1'b0;
        entPrio[i] <= '0;
        entId[i]   <= '0;
      end else if (strb.claim && bestValid && bestVirt && bestIdx == IDX_W'(i)) begin
        entInFl[i] <= 1'b1;
      end
    end

    always_comb begin
      entryWords[i*32 +: 32]              = '0;
      entryWords[i*32 + 31]               = entInFl[i];
      entryWords[i*32 + 16 +: PRIO_W]     = entPrio[i];
      entryWords[i*32 +: ID_W]            = entId[i];
    end

    // R8: a matching complete leaves the entry empty
    a_r8_complete_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strb.complete && entHit[i]) |=> (entId[i] == '0 && !entInFl[i]));
  end

  // R6: a claim that picks an entry marks that entry in flight
  a_r6_claim_inflight: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claim && bestValid && bestVirt) |=> entInFl[$past(bestIdx)]);

  // R7: an empty claim leaves every entry untouched
  a_r7_empty_claim_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claim && !bestValid) |=> $stable(entryWords));
endmodule

// File: rtl/virq_inject_ctl.sv
module virq_inject_ctl
  import virq_inject_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_PHYS    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic                      regRe,
  input  logic [7:0]                regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  input  logic [NUM_ENTRIES*32-1:0] entryWords,
  input  logic                      bestValid,
  input  logic [ID_W-1:0]           bestId,
  input  logic                      anyPending,
  input  logic                      completeHit,
  output virq_strobe_t              strb,
  output logic                      mgmtIrq
);
  logic [5:0]      wordIdx;
  logic            isEntry;
  logic            isClaim;
  logic            isMgmt;
  logic [ID_W-1:0] cmpId;
  logic            unmEvt;
  logic            mgmtWr;
  logic            enNoPend;
  logic            enUnm;
  logic            stUnm;
  logic            stNoPend;

  assign wordIdx = regAddr[7:2];
  assign isEntry = (int'(wordIdx) < NUM_ENTRIES);
  assign isClaim = (int'(wordIdx) == WORD_CLAIM);
  assign isMgmt  = (int'(wordIdx) == WORD_MGMT);
  assign cmpId   = regWdata[ID_W-1:0];

  always_comb begin
    strb          = '0;
    strb.entryWr  = regWe && isEntry;
    strb.entryIdx = wordIdx[IDX_W-1:0];
    strb.claim    = regRe && !regWe && isClaim;
    strb.complete = regWe && isClaim;
    strb.wdata    = regWdata;
  end

  assign mgmtWr   = regWe && isMgmt;
  assign unmEvt   = strb.complete && !completeHit && (cmpId != '0) &&
                    (int'(cmpId) > NUM_PHYS);
  assign stNoPend = !anyPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enNoPend <= 1'b0;
      enUnm    <= 1'b0;
      stUnm    <= 1'b0;
    end else begin
      if (mgmtWr) begin
        enNoPend <= regWdata[8];
        enUnm    <= regWdata[9];
      end
      stUnm <= unmEvt || (stUnm && !(mgmtWr && regWdata[1]));
    end
  end

  always_comb begin
    regRdata = '0;
    if (isEntry) begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (int'(wordIdx) == i) regRdata = entryWords[i*32 +: 32];
    end else if (isClaim) begin
      regRdata[ID_W-1:0] = bestValid ? bestId : '0;
    end else if (isMgmt) begin
      regRdata[0] = stNoPend;
      regRdata[1] = stUnm;
      regRdata[8] = enNoPend;
      regRdata[9] = enUnm;
    end
  end

  assign mgmtIrq = (enNoPend && stNoPend) || (enUnm && stUnm);

  // R9: an unmatched complete outside the physical range latches the status
  a_r9_unmatched_sets: assert property (@(posedge clk) disable iff (!rstN)
    unmEvt |=> stUnm);

  // R9: the status holds until software clears it
  a_r9_unmatched_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stUnm && !(mgmtWr && regWdata[1])) |=> stUnm);
endmodule

// File: rtl/virq_inject_ctrl.sv
module virq_inject_ctrl
  import virq_inject_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_PHYS    = 8,
  parameter int PRIO_W      = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [7:0]                 regAddr,
  input  logic [31:0]                regWdata,
  output logic [31:0]                regRdata,
  input  logic [NUM_PHYS-1:0]        physPending,
  input  logic [NUM_PHYS-1:0]        physEnable,
  input  logic [NUM_PHYS*PRIO_W-1:0] physPrio,
  output logic                       guestIrq,
  output logic                       mgmtIrq
);
  virq_strobe_t              strb;
  logic [NUM_ENTRIES*32-1:0] entryWords;
  logic                      bestValid;
  logic [ID_W-1:0]           bestId;
  logic                      anyPending;
  logic                      completeHit;

  virq_inject_ctl #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PHYS(NUM_PHYS)) u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .entryWords(entryWords),
    .bestValid(bestValid), .bestId(bestId), .anyPending(anyPending),
    .completeHit(completeHit), .strb(strb), .mgmtIrq(mgmtIrq)
  );

  virq_inject_dp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PHYS(NUM_PHYS), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .physPending(physPending),
    .physEnable(physEnable), .physPrio(physPrio), .entryWords(entryWords),
    .bestValid(bestValid), .bestId(bestId), .anyPending(anyPending),
    .completeHit(completeHit)
  );

  assign guestIrq = bestValid;

  // R3: the guest line is low whenever a claim would return 0
  a_r3_line_vs_claim: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && !regWe && regAddr == 8'h40 && regRdata == 32'h0) |-> !guestIrq);
endmodule

// File: tb/virq_inject_ctrl_bench.sv
module virq_inject_ctrl_bench;
  localparam int NE = 4;
  localparam int NP = 8;
  localparam int PW = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWe = 1'b0;
  logic            regRe = 1'b0;
  logic [7:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NP-1:0]   physPending = '0;
  logic [NP-1:0]   physEnable = '0;
  logic [NP*PW-1:0] physPrio = '0;
  logic            guestIrq;
  logic            mgmtIrq;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  virq_inject_ctrl #(.NUM_ENTRIES(NE), .NUM_PHYS(NP), .PRIO_W(PW)) u_virq_inject_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .physPending(physPending),
    .physEnable(physEnable), .physPrio(physPrio), .guestIrq(guestIrq), .mgmtIrq(mgmtIrq)
  );

  // {isRead, reqNum[3:0], addr[7:0], data[31:0], expect[31:0]}
  localparam int NV = 23;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 4'd1,  8'h44, 32'h0,        32'h00000001}, // R1 mgmt reset
    {1'b1, 4'd7,  8'h40, 32'h0,        32'h00000000}, // R7 empty claim
    {1'b0, 4'd2,  8'h00, 32'h00020005, 32'h0},
    {1'b0, 4'd2,  8'h04, 32'h00050009, 32'h0},
    {1'b0, 4'd2,  8'h08, 32'h00050007, 32'h0},
    {1'b0, 4'd2,  8'h30, 32'h00001234, 32'h0},
    {1'b1, 4'd2,  8'h04, 32'h0,        32'h00050009}, // R2 readback
    {1'b1, 4'd2,  8'h30, 32'h0,        32'h00000000}, // R2 out of range
    {1'b1, 4'd10, 8'h44, 32'h0,        32'h00000000}, // R10 pending exists
    {1'b1, 4'd5,  8'h40, 32'h0,        32'h00000007}, // R5 tie lowest id
    {1'b1, 4'd6,  8'h08, 32'h0,        32'h80050007}, // R6 in flight
    {1'b1, 4'd4,  8'h40, 32'h0,        32'h00000009}, // R4
    {1'b1, 4'd4,  8'h40, 32'h0,        32'h00000005}, // R4
    {1'b1, 4'd7,  8'h40, 32'h0,        32'h00000000}, // R7 all in flight
    {1'b1, 4'd10, 8'h44, 32'h0,        32'h00000001}, // R10 none pending
    {1'b0, 4'd8,  8'h40, 32'h00000009, 32'h0},
    {1'b1, 4'd8,  8'h04, 32'h0,        32'h00000000}, // R8 cleared
    {1'b0, 4'd9,  8'h40, 32'h000003FF, 32'h0},
    {1'b1, 4'd9,  8'h44, 32'h0,        32'h00000003}, // R9 latched
    {1'b0, 4'd9,  8'h44, 32'h00000302, 32'h0},
    {1'b1, 4'd9,  8'h44, 32'h0,        32'h00000301}, // R9 cleared, enables
    {1'b0, 4'd8,  8'h40, 32'h00000005, 32'h0},
    {1'b1, 4'd8,  8'h00, 32'h0,        32'h00000000}  // R8 cleared
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 guestIrq", {31'b0, guestIrq}, 32'h0);
    check("R1 mgmtIrq", {31'b0, mgmtIrq}, 32'h0);
    busRead(8'h00, rd); check("R1 entry0", rd, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][76]) begin
        busRead(VEC[v][71:64], rd);
        check($sformatf("R%0d vec%0d", VEC[v][75:72], v), rd, VEC[v][31:0]);
      end else begin
        busWrite(VEC[v][71:64], VEC[v][63:32]);
      end
    end

    // R10: no-pending event enabled, R3: only an in-flight entry remains
    check("R10 mgmtIrq level", {31'b0, mgmtIrq}, 32'h1);
    check("R3 guestIrq idle", {31'b0, guestIrq}, 32'h0);

    // R3: zero-priority entry is pending but never selectable
    busWrite(8'h0C, 32'h00000002);
    busRead(8'h44, rd); check("R10 prio0 counts pending", rd, 32'h00000300);
    check("R3 prio0 no line", {31'b0, guestIrq}, 32'h0);
    busRead(8'h40, rd); check("R7 prio0 claim", rd, 32'h0);
    busRead(8'h0C, rd); check("R7 entry unchanged", rd, 32'h00000002);
    busWrite(8'h40, 32'h00000002);

    // R4/R5/R6: virtual vs physical with same id; disabled source ignored
    physPrio[2*PW +: PW] = 3'd4; physPending[2] = 1'b1; physEnable[2] = 1'b1;
    physPrio[6*PW +: PW] = 3'd6; physPending[6] = 1'b1; physEnable[6] = 1'b0;
    busWrite(8'h04, 32'h00040003);
    check("R3 guestIrq raised", {31'b0, guestIrq}, 32'h1);
    busRead(8'h40, rd); check("R5 virtual wins tie", rd, 32'h3);
    busRead(8'h04, rd); check("R6 entry in flight", rd, 32'h80040003);
    busRead(8'h40, rd); check("R4 physical claimed", rd, 32'h3);
    busRead(8'h04, rd); check("R6 physical claim no change", rd, 32'h80040003);
    physEnable[6] = 1'b1;
    busRead(8'h40, rd); check("R4 enabled higher prio", rd, 32'h7);

    // R8/R9: physical-range completes never flag
    busWrite(8'h40, 32'h00000003);
    busRead(8'h04, rd); check("R8 complete clears", rd, 32'h0);
    busWrite(8'h40, 32'h00000004);
    busRead(8'h44, rd); check("R9 phys range no event", rd, 32'h00000301);

    // R8: every matching entry is cleared
    busWrite(8'h00, 32'h00010006);
    busWrite(8'h0C, 32'h00020006);
    busWrite(8'h40, 32'h00000006);
    busRead(8'h00, rd); check("R8 multi clear e0", rd, 32'h0);
    busRead(8'h0C, rd); check("R8 multi clear e3", rd, 32'h0);

    // R1: reset in mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    physPending = '0;
    busRead(8'h08, rd); check("R1 entry after reset", rd, 32'h0);
    busRead(8'h44, rd); check("R1 mgmt after reset", rd, 32'h00000001);
    check("R1 mgmtIrq after reset", {31'b0, mgmtIrq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule